// File: doc/BRIEF.md
# Indexed Interrupt Router

This block gathers a configurable number of interrupt request lines from the rest of a chip and delivers them to a small set of host interrupt outputs. Each request line feeds a sticky pending bit. A request reaches its host output only when its own enable is set, the host enable of its channel is set and the single global enable is set. A one-byte channel entry for each request line selects which host output the line drives. The block has no priority logic, so all lines that map to the same host output are simply ORed together.

Software uses a plain 32-bit register bus. To change a single bit, it writes the number of an interrupt or host to an index register, and no read-modify-write is needed. Word-wide set and clear bitmaps with write-1-to-act behaviour handle up to 32 interrupts per access. The pending and enable state can be read back through the same bitmaps. The set-pending index register lets software fire any interrupt during testing.

Top module: `idx_irq_router`

## Requirements
- R1: After reset, every pending bit, interrupt enable, host enable, the global enable, every channel entry and every host output is 0, and all readable registers return 0.
- R2: A request input that is high at a clock edge sets its pending bit. The bit stays set after the input falls and clears only on a software clear. If a set and a clear reach the same bit in one cycle, the bit ends up set.
- R3: Writing interrupt number n to offset 0x20 sets pending bit n. Writing n to offset 0x24 clears it.
- R4: Writing interrupt number n to offset 0x28 sets the enable of interrupt n. Writing n to offset 0x2C clears it.
- R5: Writing host number h to offset 0x34 sets the enable of host output h. Writing h to offset 0x38 clears it.
- R6: Bit 0 of offset 0x10 is the global enable and reads back there. While it is 0 every host output is 0. Changing it never alters any host enable.
- R7: There are four bitmap banks, each with one 32-bit word per group of 32 interrupts, and bit n of word k stands for interrupt 32k+n. Bank 0x200 reads the pending bits, and writing 1s there sets pending bits. Bank 0x280 reads pending AND enabled, and writing 1s there clears pending bits. Bank 0x300 sets enables for the bits written as 1. Bank 0x380 clears enables for the bits written as 1. Banks 0x300 and 0x380 both read the enables. Bits written as 0 change nothing.
- R8: Word w at offset 0x400+4w holds the channel of interrupt 4w+b in bits [8b+7:8b], and the word reads back in the same layout. A byte value at or above the number of hosts leaves that entry unchanged.
- R9: Host output h is a register that updates one cycle after the state it depends on. It is 1 when the global enable and host enable h are set and at least one interrupt with channel h is both pending and enabled.
- R10: An index write whose value is not below the interrupt count (or the host count, for the host registers) changes nothing.
- R11: Read data appears on bus_rdata in the cycle after the read strobe and holds until the next read. Any offset not listed above reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| irq_in | input | N_SYS | Interrupt request lines, one per system interrupt |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| host_irq | output | N_HOST | Host interrupt outputs |

## Verification
Embedded properties watch, on every cycle, four things: a pending bit falls only after a clear command; a request that was high is reflected in the pending bits one cycle later; a host output never rises while its host enable or the global enable was low, or while no source was active; and an out-of-range index write leaves the state untouched. Several behaviours are visible only in the bench scenarios: the exact bit and byte positions of the bitmaps and channel map, the win of a set over a clear in the same cycle, the survival of host enables across global enable toggles, and the OR of several interrupts that share one channel. A reference model in the bench follows a long stream of random index, bitmap, map and request traffic, and it checks every host output and many register reads against that model.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFS_GLOBAL   = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_PEND_SET = 12'h020;
  localparam logic [ADDR_W-1:0] OFS_PEND_CLR = 12'h024;
  localparam logic [ADDR_W-1:0] OFS_ENA_SET  = 12'h028;
  localparam logic [ADDR_W-1:0] OFS_ENA_CLR  = 12'h02C;
  localparam logic [ADDR_W-1:0] OFS_HOST_SET = 12'h034;
  localparam logic [ADDR_W-1:0] OFS_HOST_CLR = 12'h038;

  localparam logic [1:0] BANK_RAW  = 2'b00;
  localparam logic [1:0] BANK_STAT = 2'b01;
  localparam logic [1:0] BANK_ESET = 2'b10;
  localparam logic [1:0] BANK_ECLR = 2'b11;

  typedef struct packed {
    logic glob_we;
    logic pidx_set;
    logic pidx_clr;
    logic eidx_set;
    logic eidx_clr;
    logic hidx_set;
    logic hidx_clr;
    logic raw_set_we;
    logic stat_clr_we;
    logic ena_set_we;
    logic ena_clr_we;
    logic map_we;
  } wr_cmd_t;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_GLOB,
    RD_RAW,
    RD_STAT,
    RD_ENA,
    RD_MAP
  } rd_sel_t;

endpackage

// File: rtl/irq_router_decode.sv
module irq_router_decode
  import irq_router_pkg::*;
(
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output wr_cmd_t           cmd,
  output rd_sel_t           rd_sel,
  output logic [4:0]        bm_word,
  output logic [7:0]        map_word
);

  logic       wr_go;
  logic       in_bank;
  logic       in_map;
  logic [1:0] bank_kind;

  assign wr_go     = bus_en & bus_we;
  assign in_bank   = (bus_addr[11:9] == 3'b001);
  assign in_map    = (bus_addr[11:10] == 2'b01);
  assign bank_kind = bus_addr[8:7];
  assign bm_word   = bus_addr[6:2];
  assign map_word  = bus_addr[9:2];

  always_comb begin
    cmd = '0;
    if (wr_go) begin
      cmd.glob_we     = (bus_addr == OFS_GLOBAL);
      cmd.pidx_set    = (bus_addr == OFS_PEND_SET);
      cmd.pidx_clr    = (bus_addr == OFS_PEND_CLR);
      cmd.eidx_set    = (bus_addr == OFS_ENA_SET);
      cmd.eidx_clr    = (bus_addr == OFS_ENA_CLR);
      cmd.hidx_set    = (bus_addr == OFS_HOST_SET);
      cmd.hidx_clr    = (bus_addr == OFS_HOST_CLR);
      cmd.raw_set_we  = in_bank && (bank_kind == BANK_RAW);
      cmd.stat_clr_we = in_bank && (bank_kind == BANK_STAT);
      cmd.ena_set_we  = in_bank && (bank_kind == BANK_ESET);
      cmd.ena_clr_we  = in_bank && (bank_kind == BANK_ECLR);
      cmd.map_we      = in_map;
    end
  end

  always_comb begin
    rd_sel = RD_NONE;
    if (in_bank) begin
      case (bank_kind)
        BANK_RAW:  rd_sel = RD_RAW;
        BANK_STAT: rd_sel = RD_STAT;
        default:   rd_sel = RD_ENA;
      endcase
    end else if (in_map) begin
      rd_sel = RD_MAP;
    end else if (bus_addr == OFS_GLOBAL) begin
      rd_sel = RD_GLOB;
    end
  end

endmodule

// File: rtl/irq_router_status.sv
module irq_router_status
  import irq_router_pkg::*;
#(
  parameter int unsigned N_SYS  = 64,
  parameter int unsigned N_HOST = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SYS-1:0] irq_in,
  input  wr_cmd_t          cmd,
  input  logic [4:0]       bm_word,
  input  logic [BUS_W-1:0] wdata,
  output logic [N_SYS-1:0]  pend_q,
  output logic [N_SYS-1:0]  ena_q,
  output logic [N_HOST-1:0] hen_q,
  output logic              glob_q
);

  localparam int unsigned IDX_W  = (N_SYS > 1) ? $clog2(N_SYS) : 1;
  localparam int unsigned HIDX_W = (N_HOST > 1) ? $clog2(N_HOST) : 1;

  logic              sys_ok;
  logic              host_ok;
  logic [IDX_W-1:0]  sys_idx;
  logic [HIDX_W-1:0] host_idx;

  logic [N_SYS-1:0]  set_vec, clr_vec, ena_on, ena_off;
  logic [N_HOST-1:0] hen_on, hen_off;
  logic [N_SYS-1:0]  pend_nxt, ena_nxt;
  logic [N_HOST-1:0] hen_nxt;
  logic              glob_nxt;
  logic              unused_map_we;

  assign unused_map_we = cmd.map_we;
  assign sys_ok   = (wdata < BUS_W'(N_SYS));
  assign host_ok  = (wdata < BUS_W'(N_HOST));
  assign sys_idx  = wdata[IDX_W-1:0];
  assign host_idx = wdata[HIDX_W-1:0];

  for (genvar i = 0; i < N_SYS; i++) begin : g_sys
    localparam int unsigned WRD = i / 32;
    localparam int unsigned BIT = i % 32;
    logic idx_hit;
    logic map_hit;
    assign idx_hit    = sys_ok && (sys_idx == IDX_W'(i));
    assign map_hit    = (bm_word == 5'(WRD)) && wdata[BIT];
    assign set_vec[i] = irq_in[i] | (cmd.pidx_set & idx_hit) | (cmd.raw_set_we & map_hit);
    assign clr_vec[i] = (cmd.pidx_clr & idx_hit) | (cmd.stat_clr_we & map_hit);
    assign ena_on[i]  = (cmd.eidx_set & idx_hit) | (cmd.ena_set_we & map_hit);
    assign ena_off[i] = (cmd.eidx_clr & idx_hit) | (cmd.ena_clr_we & map_hit);
  end

  for (genvar h = 0; h < N_HOST; h++) begin : g_host
    logic h_hit;
    assign h_hit      = host_ok && (host_idx == HIDX_W'(h));
    assign hen_on[h]  = cmd.hidx_set & h_hit;
    assign hen_off[h] = cmd.hidx_clr & h_hit;
  end

  always_comb begin
    pend_nxt = (pend_q & ~clr_vec) | set_vec;
    ena_nxt  = (ena_q & ~ena_off) | ena_on;
    hen_nxt  = (hen_q & ~hen_off) | hen_on;
    glob_nxt = cmd.glob_we ? wdata[0] : glob_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      ena_q  <= '0;
      hen_q  <= '0;
      glob_q <= 1'b0;
    end else begin
      pend_q <= pend_nxt;
      ena_q  <= ena_nxt;
      hen_q  <= hen_nxt;
      glob_q <= glob_nxt;
    end
  end

  assert_pend_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd.pidx_clr | cmd.stat_clr_we) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

  assert_input_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(irq_in) & ~pend_q) == '0));

  assert_sys_idx_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd.pidx_set | cmd.pidx_clr | cmd.eidx_set | cmd.eidx_clr)
      && (wdata >= BUS_W'(N_SYS)) && (irq_in == '0))
    |=> (pend_q == $past(pend_q)) && (ena_q == $past(ena_q)));

  assert_host_idx_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd.hidx_set | cmd.hidx_clr) && (wdata >= BUS_W'(N_HOST)))
    |=> (hen_q == $past(hen_q)));

endmodule

// File: rtl/irq_router_route.sv
module irq_router_route
  import irq_router_pkg::*;
#(
  parameter int unsigned N_SYS  = 64,
  parameter int unsigned N_HOST = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              map_we,
  input  logic [7:0]        map_word,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [N_SYS-1:0]  active,
  input  logic [N_HOST-1:0] hen_q,
  input  logic              glob_q,
  output logic [BUS_W-1:0]  map_rdata,
  output logic [N_HOST-1:0] host_irq
);

  localparam int unsigned CH_W = (N_HOST > 1) ? $clog2(N_HOST) : 1;

  logic [N_SYS*CH_W-1:0] map_flat;
  logic [N_HOST-1:0]     host_nxt;

  for (genvar i = 0; i < N_SYS; i++) begin : g_entry
    localparam int unsigned LANE = i % 4;
    localparam int unsigned WRD  = i / 4;
    logic [7:0]      lane_byte;
    logic            upd;
    logic [CH_W-1:0] ch_q, ch_nxt;

    assign lane_byte = wdata[8*LANE +: 8];
    assign upd       = map_we && (map_word == 8'(WRD))
                       && ({24'd0, lane_byte} < BUS_W'(N_HOST));
    assign ch_nxt    = upd ? lane_byte[CH_W-1:0] : ch_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ch_q <= '0;
      else        ch_q <= ch_nxt;
    end

    assign map_flat[i*CH_W +: CH_W] = ch_q;
  end

  always_comb begin
    map_rdata = '0;
    for (int i = 0; i < N_SYS; i++) begin
      if (map_word == 8'(i / 4)) begin
        map_rdata[8*(i%4) +: 8] = 8'(map_flat[i*CH_W +: CH_W]);
      end
    end
  end

  for (genvar h = 0; h < N_HOST; h++) begin : g_out
    logic [N_SYS-1:0] sel;
    for (genvar i = 0; i < N_SYS; i++) begin : g_sel
      assign sel[i] = (map_flat[i*CH_W +: CH_W] == CH_W'(h));
    end
    assign host_nxt[h] = glob_q & hen_q[h] & (|(sel & active));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) host_irq <= '0;
    else        host_irq <= host_nxt;
  end

  assert_global_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_q |=> (host_irq == '0));

  assert_host_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((host_irq & ~$past(hen_q)) == '0));

  assert_needs_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active == '0) |=> (host_irq == '0));

endmodule

// File: rtl/idx_irq_router.sv
module idx_irq_router
  import irq_router_pkg::*;
#(
  parameter int unsigned N_SYS  = 64,
  parameter int unsigned N_HOST = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SYS-1:0]  irq_in,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [11:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [N_HOST-1:0] host_irq
);

  localparam int unsigned NWORDS = (N_SYS + 31) / 32;
  localparam int unsigned PAD_W  = NWORDS * 32;

  logic [1:0]        rst_pipe;
  logic              rst_core_n;
  wr_cmd_t           cmd;
  rd_sel_t           rd_sel;
  logic [4:0]        bm_word;
  logic [7:0]        map_word;
  logic [N_SYS-1:0]  pend_q, ena_q;
  logic [N_HOST-1:0] hen_q;
  logic              glob_q;
  logic [BUS_W-1:0]  map_rdata;
  logic [PAD_W-1:0]  pend_pad, stat_pad, ena_pad;
  logic [BUS_W-1:0]  rd_nxt, rdata_q;
  logic              rd_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  irq_router_decode u_decode (
    .bus_en   (bus_en),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .cmd      (cmd),
    .rd_sel   (rd_sel),
    .bm_word  (bm_word),
    .map_word (map_word)
  );

  irq_router_status #(.N_SYS(N_SYS), .N_HOST(N_HOST)) u_status (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .irq_in  (irq_in),
    .cmd     (cmd),
    .bm_word (bm_word),
    .wdata   (bus_wdata),
    .pend_q  (pend_q),
    .ena_q   (ena_q),
    .hen_q   (hen_q),
    .glob_q  (glob_q)
  );

  irq_router_route #(.N_SYS(N_SYS), .N_HOST(N_HOST)) u_route (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .map_we    (cmd.map_we),
    .map_word  (map_word),
    .wdata     (bus_wdata),
    .active    (pend_q & ena_q),
    .hen_q     (hen_q),
    .glob_q    (glob_q),
    .map_rdata (map_rdata),
    .host_irq  (host_irq)
  );

  assign pend_pad = PAD_W'(pend_q);
  assign stat_pad = PAD_W'(pend_q & ena_q);
  assign ena_pad  = PAD_W'(ena_q);
  assign rd_go    = bus_en & ~bus_we;

  always_comb begin
    rd_nxt = '0;
    case (rd_sel)
      RD_GLOB: rd_nxt = {31'd0, glob_q};
      RD_MAP:  rd_nxt = map_rdata;
      RD_RAW, RD_STAT, RD_ENA: begin
        for (int w = 0; w < NWORDS; w++) begin
          if (bm_word == 5'(w)) begin
            if (rd_sel == RD_RAW)       rd_nxt = pend_pad[32*w +: 32];
            else if (rd_sel == RD_STAT) rd_nxt = stat_pad[32*w +: 32];
            else                        rd_nxt = ena_pad[32*w +: 32];
          end
        end
      end
      default: rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  rdata_q <= '0;
    else if (rd_go)   rdata_q <= rd_nxt;
  end
  assign bus_rdata = rdata_q;

endmodule

// File: tb/idx_irq_router_test.sv
module idx_irq_router_test;

  localparam int N_SYS  = 64;
  localparam int N_HOST = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [N_SYS-1:0]  irq_in;
  logic              bus_en, bus_we;
  logic [11:0]       bus_addr;
  logic [31:0]       bus_wdata;
  logic [31:0]       bus_rdata;
  logic [N_HOST-1:0] host_irq;

  always #10 clk = ~clk;

  idx_irq_router #(.N_SYS(N_SYS), .N_HOST(N_HOST)) uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .host_irq(host_irq)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [N_SYS-1:0]  m_pend, m_ena;
  logic [N_HOST-1:0] m_hen;
  logic              m_glob;
  logic [7:0]        m_map [N_SYS];

  function automatic logic [N_HOST-1:0] exp_host();
    logic [N_HOST-1:0] r;
    r = '0;
    for (int h = 0; h < N_HOST; h++) begin
      logic hit;
      hit = 1'b0;
      for (int i = 0; i < N_SYS; i++)
        if (m_map[i] == 8'(h) && m_pend[i] && m_ena[i]) hit = 1'b1;
      r[h] = m_glob & m_hen[h] & hit;
    end
    return r;
  endfunction

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    logic [31:0] r;
    int w;
    r = '0;
    if (a == 12'h010) begin
      r = {31'd0, m_glob};
    end else if (a >= 12'h200 && a < 12'h400) begin
      w = int'(a[6:2]);
      if (w < N_SYS / 32) begin
        case (a[8:7])
          2'b00:   r = m_pend[32*w +: 32];
          2'b01:   r = m_pend[32*w +: 32] & m_ena[32*w +: 32];
          default: r = m_ena[32*w +: 32];
        endcase
      end
    end else if (a >= 12'h400 && a < 12'h800) begin
      w = int'(a[9:2]);
      for (int b = 0; b < 4; b++)
        if (4*w + b < N_SYS) r[8*b +: 8] = m_map[4*w + b];
    end
    return r;
  endfunction

  task automatic model_write(input logic [11:0] a, input logic [31:0] d);
    int w;
    case (a)
      12'h010: m_glob = d[0];
      12'h020: if (d < N_SYS) m_pend[d[5:0]] = 1'b1;
      12'h024: if (d < N_SYS) m_pend[d[5:0]] = 1'b0;
      12'h028: if (d < N_SYS) m_ena[d[5:0]] = 1'b1;
      12'h02C: if (d < N_SYS) m_ena[d[5:0]] = 1'b0;
      12'h034: if (d < N_HOST) m_hen[d[2:0]] = 1'b1;
      12'h038: if (d < N_HOST) m_hen[d[2:0]] = 1'b0;
      default: begin
        if (a >= 12'h200 && a < 12'h400) begin
          w = int'(a[6:2]);
          if (w < N_SYS / 32) begin
            for (int n = 0; n < 32; n++) begin
              if (d[n]) begin
                case (a[8:7])
                  2'b00:   m_pend[32*w + n] = 1'b1;
                  2'b01:   m_pend[32*w + n] = 1'b0;
                  2'b10:   m_ena[32*w + n]  = 1'b1;
                  default: m_ena[32*w + n]  = 1'b0;
                endcase
              end
            end
          end
        end else if (a >= 12'h400 && a < 12'h800) begin
          w = int'(a[9:2]);
          for (int b = 0; b < 4; b++)
            if (4*w + b < N_SYS && d[8*b +: 8] < N_HOST) m_map[4*w + b] = d[8*b +: 8];
        end
      end
    endcase
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_irq(input logic [11:0] a, input logic [31:0] d, input logic [N_SYS-1:0] v);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; irq_in = v;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; irq_in = '0;
    model_write(a, d);
    m_pend = m_pend | v;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_irq(a, d, '0);
  endtask

  task automatic pulse(input logic [N_SYS-1:0] v);
    @(negedge clk);
    irq_in = v;
    @(negedge clk);
    irq_in = '0;
    m_pend = m_pend | v;
  endtask

  task automatic rd(input string req, input logic [11:0] a);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    chk(req, bus_rdata, exp_read(a));
  endtask

  task automatic chk_host(input string req);
    @(negedge clk);
    chk(req, 32'(host_irq), 32'(exp_host()));
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    m_pend = '0; m_ena = '0; m_hen = '0; m_glob = 1'b0;
    for (int i = 0; i < N_SYS; i++) m_map[i] = 8'd0;
    rst_n = 1'b0; irq_in = '0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1", 32'(host_irq), 32'd0);
    rd("R1", 12'h200); rd("R1", 12'h204); rd("R1", 12'h300);
    rd("R1", 12'h400); rd("R1", 12'h43C); rd("R1", 12'h010);
    // R11 unmapped reads
    rd("R11", 12'h044); rd("R11", 12'h020);

    // R2 capture, stickiness, set beats clear
    pulse(64'd1 << 5);
    rd("R2", 12'h200);
    wr_irq(12'h024, 32'd5, 64'd1 << 5);
    rd("R2", 12'h200);
    wr(12'h024, 32'd5);
    rd("R2", 12'h200);

    // R3 index pending set/clear
    wr(12'h020, 32'd40); rd("R3", 12'h204);
    wr(12'h024, 32'd40); rd("R3", 12'h204);

    // R4 index enable
    wr(12'h028, 32'd3); rd("R4", 12'h300); rd("R4", 12'h380);
    wr(12'h028, 32'd50); wr(12'h02C, 32'd50); rd("R4", 12'h304);

    // R8 channel map layout and rejected byte
    wr(12'h400, 32'h0200_0000); rd("R8", 12'h400);
    wr(12'h400, 32'hFF00_0000); rd("R8", 12'h400);

    // R9 / R5 / R6 gating
    wr(12'h020, 32'd3); wr(12'h034, 32'd2); wr(12'h010, 32'd1);
    chk_host("R9");
    wr(12'h010, 32'd0); chk_host("R6");
    wr(12'h010, 32'd1); chk_host("R6"); rd("R6", 12'h010);
    wr(12'h038, 32'd2); chk_host("R5");
    wr(12'h034, 32'd2); chk_host("R5");

    // R10 out-of-range indices
    wr(12'h034, 32'd8); wr(12'h020, 32'd64); wr(12'h028, 32'd100); wr(12'h024, 32'd67);
    rd("R10", 12'h200); rd("R10", 12'h204); rd("R10", 12'h300); rd("R10", 12'h304);
    chk_host("R10");

    // R9 sharing a channel
    wr(12'h408, 32'h0002_0000); wr(12'h028, 32'd10); wr(12'h020, 32'd10);
    wr(12'h024, 32'd3); chk_host("R9");

    // R7 bitmaps
    wr(12'h280, 32'h0000_0400); chk_host("R7"); rd("R7", 12'h280);
    wr(12'h204, 32'h8000_0001); rd("R7", 12'h204);
    wr(12'h304, 32'h0000_0001); rd("R7", 12'h284); rd("R7", 12'h384);
    wr(12'h384, 32'h0000_0000); rd("R7", 12'h304);
    wr(12'h380, 32'hFFFF_FFFF); rd("R7", 12'h300);

    // random traffic against the model
    for (int it = 0; it < 600; it++) begin
      int op;
      logic [31:0] d;
      op = int'($urandom % 10);
      case (op)
        0: wr(12'h020, $urandom % 70);
        1: wr(12'h024, $urandom % 70);
        2: wr(12'h028, $urandom % 70);
        3: wr(12'h02C, $urandom % 70);
        4: wr(12'h034, $urandom % 10);
        5: wr(12'h038, $urandom % 10);
        6: wr(12'h010, $urandom % 2);
        7: begin
          d = $urandom & $urandom;
          wr(12'(32'h200 + 32'h80 * ($urandom % 4) + 4 * ($urandom % 3)), d);
        end
        8: wr(12'(32'h400 + 4 * ($urandom % 18)), $urandom & 32'h0F0F_0F0F);
        default: pulse({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
      endcase
      chk_host("R9");
      if (it % 3 == 0) begin
        int k;
        k = int'($urandom % 6);
        case (k)
          0: rd("R6", 12'h010);
          1: rd("R7", 12'(32'h200 + 4 * ($urandom % 3)));
          2: rd("R7", 12'(32'h280 + 4 * ($urandom % 3)));
          3: rd("R7", 12'(32'h300 + 32'h80 * ($urandom % 2) + 4 * ($urandom % 3)));
          4: rd("R8", 12'(32'h400 + 4 * ($urandom % 18)));
          default: rd("R11", 12'h030);
        endcase
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule